// File: doc/BRIEF.md
# Dual-Port Byte-Lane Memory

This block is a synthesizable on-chip memory with two fully independent ports. Each port has its own clock, reset, enable, per-lane write enables, address, write data and read data. Both ports may read or write in the same cycle. A word is made of byte lanes. Each lane holds nine bits: eight data bits and one extra bit. The extra bit has no meaning to the block; it is stored and returned exactly like the others.

Every enabled write cycle also produces a read result on the writing port. A per-port parameter selects what that result is:
- the old word (read-first);
- the merged new word (write-first);
- nothing, so the output keeps its value (keep-output).

Each port can add a second output register, which costs one more cycle of latency. A port reset clears only that port's output path; the stored words survive. When both ports access the same address in one cycle and at least one of them writes, the access is treated as corrupting. Both ports raise a clash flag and return a fill pattern.

Top module: `dpram_dual`

## Requirements
- R1: The two ports operate independently. A word written through either port is returned by a later read of that address on either port, and both ports can access different addresses in the same cycle.
- R2: In read-first mode, the output after a write cycle is the word that was stored at that address before the write.
- R3: In write-first mode, a write with all lane enables set shows the new word on the output.
- R4: In write-first mode with a partial write, written lanes show the new data and unwritten lanes show the fill lane (FILL_LANE when FILL_X is 0, unknown otherwise).
- R5: In keep-output mode, a write cycle leaves the read output and clash flag value unchanged, except that the flag is cleared.
- R6: Write-enable bit i controls lane i, which is bits [9i+8:9i] of the word. Bit 9i+8 is the extra bit and is stored like data. Lanes whose enable is low keep their stored value.
- R7: With PIPE=0, read data appears after the clock edge that samples the address. With PIPE=1, it appears one edge later.
- R8: A port reset sets that port's read data and clash flag to zero at the next edge. It takes priority over the enable and does not alter the stored words.
- R9: While a port's enable is low, its address, write data and write enables are ignored, and its read data and clash flag hold.
- R10: A clash is both ports enabled at the same address with at least one lane enable set on either port. On a clash, both ports set their clash flag and return the all-lanes fill word, with the same latency as data. A single writer's write still completes. The stored word after two writers is unspecified. The flag clears on the next enabled access that is not a clash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset of output path, active high |
| en_a | input | 1 | Port A access enable |
| lane_we_a | input | LANES | Port A per-lane write enables |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | 9*LANES | Port A write word |
| rdata_a | output | 9*LANES | Port A read word |
| clash_a | output | 1 | Port A same-address clash flag |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset of output path, active high |
| en_b | input | 1 | Port B access enable |
| lane_we_b | input | LANES | Port B per-lane write enables |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | 9*LANES | Port B write word |
| rdata_b | output | 9*LANES | Port B read word |
| clash_b | output | 1 | Port B same-address clash flag |

## Verification
The clash properties compare one port's inputs with the other port's inputs on a single clock. They therefore assume the two port clocks are the same net and that inputs are stable around each rising edge. The bench satisfies both: one clock source drives both ports of two instances with different mode and pipeline settings, and all inputs change on the falling edge. The bench reads only addresses it has already written, so a fill pattern never mixes with power-up contents. It also never reads back the address hit by the two-writer clash.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    WM_READ_FIRST  = 2'd0,
    WM_WRITE_FIRST = 2'd1,
    WM_KEEP_OUT    = 2'd2
  } wmode_e;
endpackage

// File: rtl/dpm_bank.sv
// One storage bank written by a single port; two combinational read taps.
module dpm_bank #(
  parameter int AW    = 9,
  parameter int LANES = 4
) (
  input  logic                            clk,
  input  logic [AW-1:0]                   waddr,
  input  logic [LANES-1:0]                wlane,
  input  logic [LANES*dpm_pkg::LANE_W-1:0] wdata,
  input  logic [AW-1:0]                   raddr0,
  input  logic [AW-1:0]                   raddr1,
  output logic [LANES*dpm_pkg::LANE_W-1:0] rdata0,
  output logic [LANES*dpm_pkg::LANE_W-1:0] rdata1
);
  localparam int LW    = dpm_pkg::LANE_W;
  localparam int W     = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wlane[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
    end
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/dpm_outreg.sv
// Optional second output stage; PIPE selects registered or direct path.
module dpm_outreg #(
  parameter int W    = 37,
  parameter bit PIPE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= d;
  end

  generate
    if (PIPE) begin : g_reg
      assign q = stage_q;
    end else begin : g_thru
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/dpm_port.sv
// Port control: write data encoding, mode-dependent output, clash detection.
module dpm_port
  import dpm_pkg::*;
#(
  parameter int          AW        = 9,
  parameter int          LANES     = 4,
  parameter wmode_e      MODE      = WM_READ_FIRST,
  parameter bit          PIPE      = 1'b0,
  parameter bit          FILL_X    = 1'b1,
  parameter logic [8:0]  FILL_LANE = 9'h000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [LANES-1:0]       we,
  input  logic [AW-1:0]          addr,
  input  logic [LANES*9-1:0]     din,
  input  logic [LANES*9-1:0]     own_rd,
  input  logic [LANES*9-1:0]     oth_rd,
  input  logic                   oth_en,
  input  logic                   oth_wr,
  input  logic [AW-1:0]          oth_addr,
  output logic [LANES-1:0]       bank_we,
  output logic [LANES*9-1:0]     bank_wdata,
  output logic [LANES*9-1:0]     dout,
  output logic                   coll
);
  localparam int LW = LANE_W;
  localparam int W  = LANES * LW;
  localparam logic [LW-1:0] LANE_FILL = FILL_X ? {LW{1'bx}} : FILL_LANE;

  logic [W-1:0] cur_word;
  logic [W-1:0] fill_word;
  logic [W-1:0] wf_word;
  logic         wr_any;
  logic         clash;
  logic [W-1:0] word_q;
  logic         coll_q;

  // Stored word is the XOR of both banks at this address.
  assign cur_word   = own_rd ^ oth_rd;
  assign bank_wdata = din ^ oth_rd;
  assign bank_we    = en ? we : '0;
  assign wr_any     = |we;
  assign clash      = en && oth_en && (addr == oth_addr) && (wr_any || oth_wr);

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign fill_word[l*LW +: LW] = LANE_FILL;
      assign wf_word[l*LW +: LW]   = we[l] ? din[l*LW +: LW] : LANE_FILL;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      coll_q <= 1'b0;
    end else if (en) begin
      coll_q <= clash;
      if (clash) begin
        word_q <= fill_word;
      end else if (wr_any) begin
        case (MODE)
          WM_READ_FIRST:  word_q <= cur_word;
          WM_WRITE_FIRST: word_q <= wf_word;
          default:        word_q <= word_q;
        endcase
      end else begin
        word_q <= cur_word;
      end
    end
  end

  dpm_outreg #(.W(W + 1), .PIPE(PIPE)) u_out (
    .clk (clk),
    .rst (rst),
    .d   ({coll_q, word_q}),
    .q   ({coll, dout})
  );
endmodule

// File: rtl/dpram_dual.sv
// Two independent ports over a pair of single-writer banks.
module dpram_dual
  import dpm_pkg::*;
#(
  parameter int         ADDR_W    = 9,
  parameter int         LANES     = 4,
  parameter wmode_e     MODE_A    = WM_READ_FIRST,
  parameter wmode_e     MODE_B    = WM_WRITE_FIRST,
  parameter bit         PIPE_A    = 1'b0,
  parameter bit         PIPE_B    = 1'b1,
  parameter bit         FILL_X    = 1'b1,
  parameter logic [8:0] FILL_LANE = 9'h000
) (
  input  logic                 clk_a,
  input  logic                 rst_a,
  input  logic                 en_a,
  input  logic [LANES-1:0]     lane_we_a,
  input  logic [ADDR_W-1:0]    addr_a,
  input  logic [LANES*9-1:0]   wdata_a,
  output logic [LANES*9-1:0]   rdata_a,
  output logic                 clash_a,
  input  logic                 clk_b,
  input  logic                 rst_b,
  input  logic                 en_b,
  input  logic [LANES-1:0]     lane_we_b,
  input  logic [ADDR_W-1:0]    addr_b,
  input  logic [LANES*9-1:0]   wdata_b,
  output logic [LANES*9-1:0]   rdata_b,
  output logic                 clash_b
);
  localparam int W = LANES * LANE_W;

  logic [W-1:0]     bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;
  logic [LANES-1:0] wl_a, wl_b;
  logic [W-1:0]     wd_a, wd_b;

  dpm_bank #(.AW(ADDR_W), .LANES(LANES)) u_bank_a (
    .clk(clk_a), .waddr(addr_a), .wlane(wl_a), .wdata(wd_a),
    .raddr0(addr_a), .raddr1(addr_b),
    .rdata0(bank_a_at_a), .rdata1(bank_a_at_b)
  );

  dpm_bank #(.AW(ADDR_W), .LANES(LANES)) u_bank_b (
    .clk(clk_b), .waddr(addr_b), .wlane(wl_b), .wdata(wd_b),
    .raddr0(addr_a), .raddr1(addr_b),
    .rdata0(bank_b_at_a), .rdata1(bank_b_at_b)
  );

  dpm_port #(
    .AW(ADDR_W), .LANES(LANES), .MODE(MODE_A), .PIPE(PIPE_A),
    .FILL_X(FILL_X), .FILL_LANE(FILL_LANE)
  ) u_port_a (
    .clk(clk_a), .rst(rst_a), .en(en_a), .we(lane_we_a), .addr(addr_a),
    .din(wdata_a), .own_rd(bank_a_at_a), .oth_rd(bank_b_at_a),
    .oth_en(en_b), .oth_wr(|lane_we_b), .oth_addr(addr_b),
    .bank_we(wl_a), .bank_wdata(wd_a), .dout(rdata_a), .coll(clash_a)
  );

  dpm_port #(
    .AW(ADDR_W), .LANES(LANES), .MODE(MODE_B), .PIPE(PIPE_B),
    .FILL_X(FILL_X), .FILL_LANE(FILL_LANE)
  ) u_port_b (
    .clk(clk_b), .rst(rst_b), .en(en_b), .we(lane_we_b), .addr(addr_b),
    .din(wdata_b), .own_rd(bank_b_at_b), .oth_rd(bank_a_at_b),
    .oth_en(en_a), .oth_wr(|lane_we_a), .oth_addr(addr_a),
    .bank_we(wl_b), .bank_wdata(wd_b), .dout(rdata_b), .coll(clash_b)
  );
endmodule

// File: rtl/dpm_chk.sv
// Per-port property checker; both port clocks are taken to be one net.
module dpm_chk
  import dpm_pkg::*;
#(
  parameter int         AW        = 9,
  parameter int         LANES     = 4,
  parameter wmode_e     MODE      = WM_READ_FIRST,
  parameter bit         PIPE      = 1'b0,
  parameter bit         FILL_X    = 1'b1,
  parameter logic [8:0] FILL_LANE = 9'h000
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic [LANES-1:0]   we,
  input logic [AW-1:0]      addr,
  input logic [LANES*9-1:0] din,
  input logic [LANES*9-1:0] dout,
  input logic               coll,
  input logic               o_en,
  input logic [LANES-1:0]   o_we,
  input logic [AW-1:0]      o_addr
);
  logic hit;
  assign hit = en && o_en && (addr == o_addr) && ((|we) || (|o_we));

  // R8: reset leaves zero data and a clear flag
  p_rst_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dout == '0) && !coll);

  // R10: while the flag is up the data is the fill word
  p_coll_fill_r10: assert property (@(posedge clk) disable iff (rst)
    (!FILL_X && coll) |-> (dout == {LANES{FILL_LANE}}));

  generate
    if (PIPE) begin : g_p1
      p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ##1 ($stable(dout) && $stable(coll)));
      p_coll_flag_r10: assert property (@(posedge clk) disable iff (rst)
        hit |=> ##1 coll);
      p_wf_full_r3: assert property (@(posedge clk) disable iff (rst)
        (MODE == WM_WRITE_FIRST && en && (&we) && !hit) |=> ##1 (dout == $past(din, 2)));
      p_keep_out_r5: assert property (@(posedge clk) disable iff (rst)
        (MODE == WM_KEEP_OUT && en && (|we) && !hit) |=> ##1 $stable(dout));
    end else begin : g_p0
      p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(dout) && $stable(coll)));
      p_coll_flag_r10: assert property (@(posedge clk) disable iff (rst)
        hit |=> coll);
      p_wf_full_r3: assert property (@(posedge clk) disable iff (rst)
        (MODE == WM_WRITE_FIRST && en && (&we) && !hit) |=> (dout == $past(din)));
      p_keep_out_r5: assert property (@(posedge clk) disable iff (rst)
        (MODE == WM_KEEP_OUT && en && (|we) && !hit) |=> $stable(dout));
    end
  endgenerate
endmodule

bind dpram_dual dpm_chk #(
  .AW(ADDR_W), .LANES(LANES), .MODE(MODE_A), .PIPE(PIPE_A),
  .FILL_X(FILL_X), .FILL_LANE(FILL_LANE)
) u_chk_a (
  .clk(clk_a), .rst(rst_a), .en(en_a), .we(lane_we_a), .addr(addr_a),
  .din(wdata_a), .dout(rdata_a), .coll(clash_a),
  .o_en(en_b), .o_we(lane_we_b), .o_addr(addr_b)
);

bind dpram_dual dpm_chk #(
  .AW(ADDR_W), .LANES(LANES), .MODE(MODE_B), .PIPE(PIPE_B),
  .FILL_X(FILL_X), .FILL_LANE(FILL_LANE)
) u_chk_b (
  .clk(clk_b), .rst(rst_b), .en(en_b), .we(lane_we_b), .addr(addr_b),
  .din(wdata_b), .dout(rdata_b), .coll(clash_b),
  .o_en(en_a), .o_we(lane_we_a), .o_addr(addr_a)
);

// File: tb/test_dpram_dual.sv
module test_dpram_dual;
  import dpm_pkg::*;

  localparam logic [8:0]  FILLL = 9'h155;
  localparam logic [35:0] FILLW = {4{FILLL}};

  typedef struct packed {
    logic [3:0]  req;
    logic        rsa; logic ena; logic [3:0] wea; logic [8:0] aa; logic [35:0] da;
    logic        rsb; logic enb; logic [3:0] web; logic [8:0] ab; logic [35:0] db;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{4'd1,  1'b0,1'b1,4'hF,9'd1,36'h123456789, 1'b0,1'b1,4'hF,9'd2,36'h9ABCDEF01},
    '{4'd1,  1'b0,1'b1,4'h0,9'd2,36'h0,         1'b0,1'b1,4'h0,9'd1,36'h0},
    '{4'd3,  1'b0,1'b1,4'hF,9'd3,36'hFEDCBA987, 1'b0,1'b0,4'h0,9'd0,36'h0},
    '{4'd2,  1'b0,1'b1,4'h0,9'd3,36'h0,         1'b0,1'b1,4'hF,9'd1,36'h0F0F0F0F0},
    '{4'd4,  1'b0,1'b1,4'h5,9'd3,36'h111111111, 1'b0,1'b0,4'h0,9'd0,36'h0},
    '{4'd6,  1'b0,1'b1,4'h0,9'd3,36'h0,         1'b0,1'b0,4'h0,9'd0,36'h0},
    '{4'd6,  1'b0,1'b1,4'hF,9'd4,36'h804020100, 1'b0,1'b1,4'h0,9'd2,36'h0},
    '{4'd6,  1'b0,1'b1,4'h0,9'd4,36'h0,         1'b0,1'b1,4'h0,9'd4,36'h0},
    '{4'd9,  1'b0,1'b0,4'hF,9'd4,36'h0,         1'b0,1'b0,4'hF,9'd4,36'h0},
    '{4'd9,  1'b0,1'b1,4'h0,9'd4,36'h0,         1'b0,1'b1,4'h0,9'd1,36'h0},
    '{4'd10, 1'b0,1'b1,4'h0,9'd1,36'h0,         1'b0,1'b1,4'hF,9'd1,36'h0AAAAAAAA},
    '{4'd10, 1'b0,1'b1,4'h0,9'd1,36'h0,         1'b0,1'b0,4'h0,9'd0,36'h0},
    '{4'd10, 1'b0,1'b1,4'hF,9'd6,36'h111111111, 1'b0,1'b1,4'hF,9'd6,36'h222222222},
    '{4'd1,  1'b0,1'b1,4'h0,9'd2,36'h0,         1'b0,1'b1,4'h0,9'd3,36'h0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_a, en_a, rst_b, en_b;
  logic [3:0]  we_a, we_b;
  logic [8:0]  ad_a, ad_b;
  logic [35:0] wd_a, wd_b;
  logic [35:0] q1a, q1b, q2a, q2b;
  logic        f1a, f1b, f2a, f2b;

  dpram_dual #(
    .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST), .PIPE_A(1'b0), .PIPE_B(1'b1),
    .FILL_X(1'b0), .FILL_LANE(FILLL)
  ) i_dpram_dual (
    .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .lane_we_a(we_a), .addr_a(ad_a),
    .wdata_a(wd_a), .rdata_a(q1a), .clash_a(f1a),
    .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .lane_we_b(we_b), .addr_b(ad_b),
    .wdata_b(wd_b), .rdata_b(q1b), .clash_b(f1b)
  );

  dpram_dual #(
    .MODE_A(WM_KEEP_OUT), .MODE_B(WM_WRITE_FIRST), .PIPE_A(1'b0), .PIPE_B(1'b1),
    .FILL_X(1'b0), .FILL_LANE(FILLL)
  ) i_dpram_dual_nc (
    .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .lane_we_a(we_a), .addr_a(ad_a),
    .wdata_a(wd_a), .rdata_a(q2a), .clash_a(f2a),
    .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .lane_we_b(we_b), .addr_b(ad_b),
    .wdata_b(wd_b), .rdata_b(q2b), .clash_b(f2b)
  );

  // Reference model: mode 0 read-first, 1 write-first, 2 keep-output.
  int          md [2][2];
  bit          pp [2][2];
  logic [35:0] refm [512];
  logic [35:0] s1 [2][2];
  logic [35:0] s2 [2][2];
  bit          c1 [2][2];
  bit          c2 [2][2];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  function automatic string rtag(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [35:0] wf_merge(input logic [3:0] we, input logic [35:0] d);
    logic [35:0] r;
    for (int l = 0; l < 4; l++) r[l*9 +: 9] = we[l] ? d[l*9 +: 9] : FILLL;
    return r;
  endfunction

  function automatic logic [35:0] mem_merge(input logic [35:0] o, input logic [3:0] we,
                                            input logic [35:0] d);
    logic [35:0] r;
    for (int l = 0; l < 4; l++) r[l*9 +: 9] = we[l] ? d[l*9 +: 9] : o[l*9 +: 9];
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [35:0] got,
                     input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input vec_t v);
    logic        rs [2];
    logic        en [2];
    logic [3:0]  we [2];
    logic [8:0]  ad [2];
    logic [35:0] dn [2];
    string       tg [2];
    logic [35:0] got [2][2];
    logic        gfl [2][2];
    bit          clash;
    rs[0] = v.rsa; en[0] = v.ena; we[0] = v.wea; ad[0] = v.aa; dn[0] = v.da;
    rs[1] = v.rsb; en[1] = v.enb; we[1] = v.web; ad[1] = v.ab; dn[1] = v.db;
    rst_a = v.rsa; en_a = v.ena; we_a = v.wea; ad_a = v.aa; wd_a = v.da;
    rst_b = v.rsb; en_b = v.enb; we_b = v.web; ad_b = v.ab; wd_b = v.db;
    clash = en[0] && en[1] && (ad[0] == ad[1]) && ((|we[0]) || (|we[1]));
    for (int p = 0; p < 2; p++) begin
      if (rs[p])            tg[p] = "R8";
      else if (!en[p])      tg[p] = "R9";
      else if (clash)       tg[p] = "R10";
      else                  tg[p] = rtag(v.req);
    end
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 2; p++) begin
        if (rs[p]) begin
          s2[d][p] = '0; c2[d][p] = 1'b0; s1[d][p] = '0; c1[d][p] = 1'b0;
        end else begin
          s2[d][p] = s1[d][p]; c2[d][p] = c1[d][p];
          if (en[p]) begin
            c1[d][p] = clash;
            if (clash)               s1[d][p] = FILLW;
            else if (|we[p]) begin
              if (md[d][p] == 0)      s1[d][p] = refm[ad[p]];
              else if (md[d][p] == 1) s1[d][p] = wf_merge(we[p], dn[p]);
            end else                 s1[d][p] = refm[ad[p]];
          end
        end
      end
    end
    for (int p = 0; p < 2; p++)
      if (en[p] && (|we[p])) refm[ad[p]] = mem_merge(refm[ad[p]], we[p], dn[p]);
    @(posedge clk);
    @(negedge clk);
    got[0][0] = q1a; got[0][1] = q1b; got[1][0] = q2a; got[1][1] = q2b;
    gfl[0][0] = f1a; gfl[0][1] = f1b; gfl[1][0] = f2a; gfl[1][1] = f2b;
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 2; p++) begin
        chk(tg[p], $sformatf("dut%0d port%0d data", d, p), got[d][p],
            pp[d][p] ? s2[d][p] : s1[d][p]);
        chk(tg[p], $sformatf("dut%0d port%0d clash", d, p), {35'd0, gfl[d][p]},
            {35'd0, pp[d][p] ? c2[d][p] : c1[d][p]});
      end
    end
  endtask

  function automatic vec_t mk(input logic [3:0] req, input logic rsa, input logic ena,
                              input logic [8:0] aa, input logic rsb, input logic enb,
                              input logic [8:0] ab);
    return '{req, rsa, ena, 4'h0, aa, 36'h0, rsb, enb, 4'h0, ab, 36'h0};
  endfunction

  initial begin
    md[0][0] = 1; md[0][1] = 0; md[1][0] = 2; md[1][1] = 1;
    pp[0][0] = 1'b0; pp[0][1] = 1'b1; pp[1][0] = 1'b0; pp[1][1] = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 2; p++) begin
        s1[d][p] = '0; s2[d][p] = '0; c1[d][p] = 1'b0; c2[d][p] = 1'b0;
      end
    for (int i = 0; i < 512; i++) refm[i] = '0;
    rst_a = 1'b1; rst_b = 1'b1; en_a = 1'b0; en_b = 1'b0;
    we_a = '0; we_b = '0; ad_a = '0; ad_b = '0; wd_a = '0; wd_b = '0;
    @(negedge clk);
    // R8: reset state of both instances
    cyc(mk(4'd8, 1'b1, 1'b0, 9'd0, 1'b1, 1'b0, 9'd0));
    cyc(mk(4'd8, 1'b1, 1'b0, 9'd0, 1'b1, 1'b0, 9'd0));
    for (int i = 0; i < NV; i++) cyc(TBL[i]);
    // R8: reset with enable high, then stored words still readable
    cyc(mk(4'd8, 1'b1, 1'b1, 9'd2, 1'b1, 1'b1, 9'd3));
    cyc(mk(4'd8, 1'b0, 1'b1, 9'd2, 1'b0, 1'b1, 9'd3));
    // R7: pipelined port B shows each read one edge late
    cyc(mk(4'd7, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1, 9'd4));
    cyc(mk(4'd7, 1'b0, 1'b0, 9'd0, 1'b0, 1'b1, 9'd2));
    cyc(mk(4'd7, 1'b0, 1'b1, 9'd1, 1'b0, 1'b1, 9'd1));
    cyc(mk(4'd7, 1'b0, 1'b1, 9'd3, 1'b0, 1'b1, 9'd4));
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule